// File: doc/BRIEF.md
# Almost-Flag Offset Unit

This block keeps the two thresholds that decide when a FIFO is nearly empty or nearly full, and turns the FIFO's current fill level into two active-low warning flags. The FIFO storage and its pointers live elsewhere. The fill level arrives on the `level` input, and this unit only compares it against the stored thresholds.

Both thresholds start from one of eight built-in values. The value is chosen while master reset is held. Software-style loading then happens through the FIFO's own write port, in one of two ways:
- in parallel, one threshold per write-clock edge;
- serially, one bit per write-clock edge.

The thresholds can be read back through the read port. A parity-layout mode chooses which write-bus bits make up a threshold during a parallel load.

The flags run in one of two timing styles, latched at master reset:
- In the synchronous style, each flag is owned by one clock.
- In the split style, a flag is raised by one clock and dropped by the other.

Load, serial-shift and readback strobes have no handshake and no back-pressure. Every clock edge that sees an enable together with `ld` acts at once, and the unit never stalls the FIFO ports.

Top module: `almost_flag_unit`

## Requirements
- R1: While `mrst_n` is low on both clocks, both thresholds become min(2^(k+3)-1, DEPTH-1), where k = {ld, cfg_dflt_sel[1], cfg_dflt_sel[0]}. This gives 7, 15, ... up to 1023. The mode pins `cfg_async_flags` and `cfg_parity_skip` are latched at the same time.
- R2: A write-clock edge with `ld` and `wr_en` both high loads one threshold from `wr_data`. Successive parallel loads alternate, empty-side threshold first and then full-side, and either reset restarts the sequence at the empty side.
- R3: With parity skip latched, the threshold bits are taken in ascending order from the bus bits that are not positions 8, 17, 26 or 35. Without parity skip, threshold bit j is `wr_data[j]`, and bits 32 to 35 never matter. Neither setting changes anything other than threshold loading.
- R4: A write-clock edge with `ld` and `ser_en` high and `wr_en` low shifts `ser_in` into a 2*OFS_W-bit chain. After 2*OFS_W shifts, the first bit shifted in is bit 0 of the empty-side threshold, and bit OFS_W+1 is bit 0 of the full-side threshold.
- R5: A read-clock edge with `ld` and `rd_en` high puts a threshold on `rd_data[OFS_W-1:0]`, with the upper bits zero. Reads alternate, empty side first, whichever load method was used. Otherwise `rd_data` holds its value.
- R6: `almost_empty_n` is low when `level` is at or below the empty-side threshold.
- R7: `almost_full_n` is low when DEPTH-`level` is at or below the full-side threshold.
- R8: In the synchronous style (`cfg_async_flags` latched 0), `almost_empty_n` updates only on read-clock edges and `almost_full_n` only on write-clock edges.
- R9: In the split style, `almost_empty_n` is set by a read-clock edge and cleared by a write-clock edge. `almost_full_n` is set by a write-clock edge and cleared by a read-clock edge.
- R10: Partial reset (`prst_n` low) keeps both thresholds and both latched modes. It restarts both load and readback sequences, clears `rd_data`, and returns the flags to their reset state.
- R11: After either reset, `almost_empty_n` is 0, `almost_full_n` is 1 and `rd_data` is 0.
- R12: When `wr_en` and `ser_en` are both high with `ld`, only the parallel load happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, synchronous to both clocks |
| prst_n | input | 1 | Partial reset, active low, synchronous to both clocks |
| cfg_async_flags | input | 1 | Flag timing style latched at master reset (1 = split) |
| cfg_parity_skip | input | 1 | Parity-skip layout latched at master reset |
| cfg_dflt_sel | input | 2 | Low bits of the default-threshold index |
| ld | input | 1 | Threshold access qualifier; also high bit of the default index |
| wr_en | input | 1 | Write enable (parallel load when `ld` is high) |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial threshold bit |
| wr_data | input | 36 | Write data bus |
| rd_en | input | 1 | Read enable (readback when `ld` is high) |
| rd_data | output | 36 | Threshold readback |
| level | input | OFS_W+1 | Current FIFO occupancy, 0 to DEPTH |
| almost_empty_n | output | 1 | Nearly-empty flag, active low |
| almost_full_n | output | 1 | Nearly-full flag, active low |

## Verification
Thresholds are loaded with random bus words in both parity layouts. Bits 8, 17 and 26 vary, so the two layouts give different results, and bits 32 to 35 vary to show they never matter. Serial chains of random bits, and cycles that mix serial and parallel strobes, show the chain order and the load priority. Fill levels are swept just around each threshold and also drawn at random, with one clock or the other randomly held still. Freezing one clock is what separates the synchronous style from the split style: an edge of only the other clock moves a flag in one style and leaves it alone in the other.

// File: rtl/afo_pkg.sv
package afo_pkg;
  localparam int BUS_W = 36;
  localparam int GROUP = 9;
  localparam int PLAIN_LIMIT = 32;

  typedef struct packed {
    logic async_flags;
    logic parity_skip;
  } afo_cfg_t;

  typedef enum logic {SIDE_EMPTY = 1'b0, SIDE_FULL = 1'b1} afo_side_e;

  function automatic int dflt_ofs(input int idx, input int depth);
    int v;
    v = (1 << (idx + 3)) - 1;
    if (v > depth - 1) v = depth - 1;
    return v;
  endfunction

  function automatic int skip_src(input int j);
    int cnt;
    cnt = 0;
    for (int i = 0; i < BUS_W; i++) begin
      if ((i % GROUP) != GROUP - 1) begin
        if (cnt == j) return i;
        cnt++;
      end
    end
    return 0;
  endfunction
endpackage

// File: rtl/afo_offset_regs.sv
module afo_offset_regs
  import afo_pkg::*;
#(
  parameter int DEPTH = 16384,
  localparam int OFS_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             prst,
  input  logic             pin_async,
  input  logic             pin_skip,
  input  logic [1:0]       pin_sel,
  input  logic             ld,
  input  logic             wr_en,
  input  logic             ser_en,
  input  logic             ser_in,
  input  logic [BUS_W-1:0] wr_data,
  output afo_cfg_t         cfg,
  output logic [OFS_W-1:0] ae_q,
  output logic [OFS_W-1:0] af_q
);
  logic [OFS_W-1:0] fld_skip, fld_plain, fld, dflt;
  logic [2:0]       dsel;
  afo_side_e        seq;

  for (genvar j = 0; j < OFS_W; j++) begin : g_map
    assign fld_skip[j]  = wr_data[skip_src(j)];
    assign fld_plain[j] = wr_data[j];
  end

  assign fld  = cfg.parity_skip ? fld_skip : fld_plain;
  assign dsel = {ld, pin_sel};
  assign dflt = OFS_W'(dflt_ofs(int'(dsel), DEPTH));

  always_ff @(posedge clk) begin
    if (mrst) begin
      cfg.async_flags <= pin_async;
      cfg.parity_skip <= pin_skip;
      ae_q <= dflt;
      af_q <= dflt;
      seq  <= SIDE_EMPTY;
    end else if (prst) begin
      seq <= SIDE_EMPTY;
    end else if (ld && wr_en) begin
      if (seq == SIDE_EMPTY) ae_q <= fld;
      else                   af_q <= fld;
      seq <= (seq == SIDE_EMPTY) ? SIDE_FULL : SIDE_EMPTY;
    end else if (ld && ser_en) begin
      {af_q, ae_q} <= {ser_in, af_q, ae_q[OFS_W-1:1]};
    end
  end

  a_r2_side_flips: assert property (@(posedge clk) disable iff (mrst)
    (!prst && ld && wr_en) |=> seq != $past(seq));
  a_r4_serial_enter: assert property (@(posedge clk) disable iff (mrst)
    (!prst && ld && !wr_en && ser_en) |=>
      (af_q[OFS_W-1] == $past(ser_in)) && (ae_q[OFS_W-2:0] == $past(ae_q[OFS_W-1:1])));
  a_r12_no_load_hold: assert property (@(posedge clk) disable iff (mrst)
    !(ld && (wr_en || ser_en)) |=> $stable(ae_q) && $stable(af_q));
  a_r10_prst_keeps: assert property (@(posedge clk) disable iff (mrst)
    prst |=> $stable(ae_q) && $stable(af_q) && $stable(cfg));
endmodule

// File: rtl/afo_readback.sv
module afo_readback
  import afo_pkg::*;
#(
  parameter int OFS_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] ae_q,
  input  logic [OFS_W-1:0] af_q,
  output logic [BUS_W-1:0] rd_data
);
  localparam int PAD_W = BUS_W - OFS_W;
  afo_side_e seq;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq     <= SIDE_EMPTY;
      rd_data <= '0;
    end else if (ld && rd_en) begin
      rd_data <= {{PAD_W{1'b0}}, (seq == SIDE_EMPTY) ? ae_q : af_q};
      seq     <= (seq == SIDE_EMPTY) ? SIDE_FULL : SIDE_EMPTY;
    end
  end

  a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !(ld && rd_en) |=> $stable(rd_data));
  a_r5_side_flips: assert property (@(posedge clk) disable iff (rst)
    (ld && rd_en) |=> seq != $past(seq));
endmodule

// File: rtl/afo_flag_cell.sv
module afo_flag_cell #(
  parameter bit RST_ASSERTED = 1'b1
) (
  input  logic clk_a,
  input  logic rst_a,
  input  logic clk_c,
  input  logic rst_c,
  input  logic async_mode,
  input  logic cond,
  output logic flag
);
  logic flag_sync, set_t, clr_t, flag_split;

  assign flag_split = set_t ^ clr_t;
  assign flag       = async_mode ? flag_split : flag_sync;

  always_ff @(posedge clk_a) begin
    if (rst_a) begin
      flag_sync <= RST_ASSERTED;
      set_t     <= RST_ASSERTED;
    end else begin
      flag_sync <= cond;
      if (async_mode && cond && !flag_split) set_t <= ~set_t;
    end
  end

  always_ff @(posedge clk_c) begin
    if (rst_c) clr_t <= 1'b0;
    else if (async_mode && !cond && flag_split) clr_t <= ~clr_t;
  end

  a_r9_set_gated: assert property (@(posedge clk_a) disable iff (rst_a)
    (!$past(rst_a) && set_t != $past(set_t)) |-> ($past(async_mode) && !$past(flag_split)));
  a_r9_clear_gated: assert property (@(posedge clk_c) disable iff (rst_c)
    (!$past(rst_c) && clr_t != $past(clr_t)) |-> ($past(async_mode) && $past(flag_split)));
endmodule

// File: rtl/almost_flag_unit.sv
module almost_flag_unit
  import afo_pkg::*;
#(
  parameter int DEPTH = 16384,
  localparam int OFS_W = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             cfg_async_flags,
  input  logic             cfg_parity_skip,
  input  logic [1:0]       cfg_dflt_sel,
  input  logic             ld,
  input  logic             wr_en,
  input  logic             ser_en,
  input  logic             ser_in,
  input  logic [35:0]      wr_data,
  input  logic             rd_en,
  output logic [35:0]      rd_data,
  input  logic [OFS_W:0]   level,
  output logic             almost_empty_n,
  output logic             almost_full_n
);
  localparam logic [OFS_W:0] DEPTH_V = (OFS_W+1)'(DEPTH);

  afo_cfg_t         cfg;
  logic [OFS_W-1:0] ae_q, af_q;
  logic [OFS_W:0]   space;
  logic             mrst, prst, rst_any, ae_cond, af_cond, ae_flag, af_flag;

  assign mrst    = !mrst_n;
  assign prst    = !prst_n;
  assign rst_any = mrst || prst;
  assign space   = DEPTH_V - level;
  assign ae_cond = level <= {1'b0, ae_q};
  assign af_cond = space <= {1'b0, af_q};

  afo_offset_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(wclk), .mrst(mrst), .prst(prst),
    .pin_async(cfg_async_flags), .pin_skip(cfg_parity_skip), .pin_sel(cfg_dflt_sel),
    .ld(ld), .wr_en(wr_en), .ser_en(ser_en), .ser_in(ser_in), .wr_data(wr_data),
    .cfg(cfg), .ae_q(ae_q), .af_q(af_q)
  );

  afo_readback #(.OFS_W(OFS_W)) u_rb (
    .clk(rclk), .rst(rst_any), .ld(ld), .rd_en(rd_en),
    .ae_q(ae_q), .af_q(af_q), .rd_data(rd_data)
  );

  afo_flag_cell #(.RST_ASSERTED(1'b1)) u_ae (
    .clk_a(rclk), .rst_a(rst_any), .clk_c(wclk), .rst_c(rst_any),
    .async_mode(cfg.async_flags), .cond(ae_cond), .flag(ae_flag)
  );

  afo_flag_cell #(.RST_ASSERTED(1'b0)) u_af (
    .clk_a(wclk), .rst_a(rst_any), .clk_c(rclk), .rst_c(rst_any),
    .async_mode(cfg.async_flags), .cond(af_cond), .flag(af_flag)
  );

  assign almost_empty_n = !ae_flag;
  assign almost_full_n  = !af_flag;

  a_r8_full_sync_on_write: assert property (@(posedge wclk) disable iff (rst_any)
    (!cfg.async_flags && $past(!cfg.async_flags) && !$past(rst_any)) |-> (almost_full_n == !$past(af_cond)));
  a_r8_empty_sync_on_read: assert property (@(posedge rclk) disable iff (rst_any)
    (!cfg.async_flags && $past(!cfg.async_flags) && !$past(rst_any)) |-> (almost_empty_n == !$past(ae_cond)));
endmodule

// File: tb/almost_flag_unit_test.sv
module almost_flag_unit_test;
  localparam int DEPTH = 16384;
  localparam int W = 14;

  logic base = 1'b0, w_on = 1'b1, r_on = 1'b1;
  logic wclk, rclk;
  logic mrst_n = 1'b0, prst_n = 1'b1, cfg_async_flags = 1'b0, cfg_parity_skip = 1'b0;
  logic [1:0] cfg_dflt_sel = 2'b00;
  logic ld = 1'b0, wr_en = 1'b0, ser_en = 1'b0, ser_in = 1'b0, rd_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data;
  logic [W:0] level = '0;
  logic almost_empty_n, almost_full_n;

  assign wclk = base & w_on;
  assign rclk = base & r_on;
  always #10 base = ~base;

  almost_flag_unit #(.DEPTH(DEPTH)) uut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .cfg_async_flags(cfg_async_flags), .cfg_parity_skip(cfg_parity_skip),
    .cfg_dflt_sel(cfg_dflt_sel), .ld(ld), .wr_en(wr_en), .ser_en(ser_en),
    .ser_in(ser_in), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .level(level), .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
  );

  int total = 0, bad = 0;
  logic [W-1:0] m_ae, m_af;
  logic [35:0] m_rd;
  bit m_wseq, m_rseq, m_async, m_skip, m_aef, m_aff;

  function automatic logic [W-1:0] exp_field(input logic [35:0] d, input bit skip);
    logic [W-1:0] f;
    int k;
    f = '0; k = 0;
    for (int i = 0; i < 36; i++) begin
      if (k < W && !(skip ? (i % 9 == 8) : (i >= 32))) begin
        f[k] = d[i]; k++;
      end
    end
    return f;
  endfunction

  function automatic logic [W-1:0] exp_dflt(input int idx);
    int v;
    v = (1 << (idx + 3)) - 1;
    if (v > DEPTH - 1) v = DEPTH - 1;
    return W'(v);
  endfunction

  task automatic tick(input bit w, input bit r);
    bit rst_any, cae, caf, amode;
    logic [W-1:0] oae, oaf;
    @(negedge base);
    w_on = w; r_on = r;
    rst_any = !mrst_n || !prst_n;
    oae = m_ae; oaf = m_af; amode = m_async;
    cae = int'(level) <= int'(oae);
    caf = (DEPTH - int'(level)) <= int'(oaf);
    if (w) begin
      if (!mrst_n) begin
        m_async = cfg_async_flags; m_skip = cfg_parity_skip;
        m_ae = exp_dflt(int'({ld, cfg_dflt_sel})); m_af = m_ae; m_wseq = 0;
      end else if (!prst_n) m_wseq = 0;
      else if (ld && wr_en) begin
        if (!m_wseq) m_ae = exp_field(wr_data, m_skip);
        else         m_af = exp_field(wr_data, m_skip);
        m_wseq = !m_wseq;
      end else if (ld && ser_en) {m_af, m_ae} = {ser_in, oaf, oae[W-1:1]};
    end
    if (r) begin
      if (rst_any) begin m_rseq = 0; m_rd = '0; end
      else if (ld && rd_en) begin
        m_rd = {22'd0, m_rseq ? oaf : oae}; m_rseq = !m_rseq;
      end
    end
    if (rst_any) begin m_aef = 1; m_aff = 0; end
    else if (!amode) begin
      if (r) m_aef = cae;
      if (w) m_aff = caf;
    end else begin
      if (r && cae) m_aef = 1;
      if (w && !cae) m_aef = 0;
      if (w && caf) m_aff = 1;
      if (r && !caf) m_aff = 0;
    end
    @(posedge base); #5;
  endtask

  task automatic chk(input string tag);
    total += 3;
    if (almost_empty_n !== !m_aef) begin
      bad++; $display("FAIL %s almost_empty_n actual=%0b expected=%0b", tag, almost_empty_n, !m_aef);
    end
    if (almost_full_n !== !m_aff) begin
      bad++; $display("FAIL %s almost_full_n actual=%0b expected=%0b", tag, almost_full_n, !m_aff);
    end
    if (rd_data !== m_rd) begin
      bad++; $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, m_rd);
    end
  endtask

  task automatic idle();
    ld = 0; wr_en = 0; ser_en = 0; rd_en = 0;
  endtask

  task automatic master_reset(input int idx, input bit am, input bit sk);
    idle();
    mrst_n = 0; ld = idx[2]; cfg_dflt_sel = idx[1:0];
    cfg_async_flags = am; cfg_parity_skip = sk;
    tick(1, 1); tick(1, 1);
    mrst_n = 1; ld = 0;
    chk("R11 after master reset");
  endtask

  task automatic read_both(input string tag);
    idle(); ld = 1; rd_en = 1;
    tick(1, 1); chk(tag);
    tick(1, 1); chk(tag);
    idle();
  endtask

  task automatic par_load(input logic [35:0] a, input logic [35:0] b);
    idle(); ld = 1; wr_en = 1;
    wr_data = a; tick(1, 1);
    wr_data = b; tick(1, 1);
    idle();
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_ae = '0; m_af = '0; m_rd = '0;
    m_wseq = 0; m_rseq = 0; m_async = 0; m_skip = 0; m_aef = 1; m_aff = 0;

    // R1 R5: every default index, read back
    for (int idx = 0; idx < 8; idx++) begin
      master_reset(idx, idx[0], idx[1]);
      read_both("R1 R5 default readback");
    end

    // R2 R3: parallel loads in both layouts with random upper/parity bits
    for (int sk = 0; sk < 2; sk++) begin
      master_reset(3, 0, sk[0]);
      for (int n = 0; n < 6; n++) begin
        par_load({$urandom, $urandom}, {$urandom, $urandom});
        read_both(sk ? "R3 skip layout" : "R3 R2 plain layout");
      end
    end

    // R4: full serial chain
    master_reset(0, 0, 0);
    idle(); ld = 1; ser_en = 1;
    for (int b = 0; b < 2 * W; b++) begin
      ser_in = $urandom_range(0, 1); tick(1, 1);
    end
    read_both("R4 serial chain");

    // R12: both strobes, parallel wins
    idle(); ld = 1; ser_en = 1; wr_en = 1; ser_in = 1; wr_data = {$urandom, $urandom};
    tick(1, 1);
    read_both("R12 parallel priority");

    // R6 R7: thresholds around the offsets in sync mode
    master_reset(0, 0, 0);
    par_load(36'd100, 36'd200);
    foreach (level[i]) ;
    for (int d = -1; d <= 1; d++) begin
      level = (W+1)'(100 + d); tick(1, 1); chk("R6 empty threshold");
      level = (W+1)'(DEPTH - 200 + d); tick(1, 1); chk("R7 full threshold");
    end

    // R8 R9: single-clock edges separate the styles
    for (int am = 0; am < 2; am++) begin
      master_reset(0, am[0], 0);
      par_load(36'd100, 36'd200);
      level = 50; tick(1, 1); chk("R8 R9 setup");
      level = 300; tick(0, 1); chk(am ? "R9 read edge keeps empty" : "R8 read edge updates empty");
      tick(1, 0); chk(am ? "R9 write edge clears empty" : "R8 write edge no empty change");
      level = 50; tick(1, 0); chk(am ? "R9 write edge no empty set" : "R8 write edge no empty set");
      tick(0, 1); chk(am ? "R9 read edge sets empty" : "R8 read edge sets empty");
      level = DEPTH - 10; tick(0, 1); chk(am ? "R9 read edge no full set" : "R8 read edge no full set");
      tick(1, 0); chk(am ? "R9 write edge sets full" : "R8 write edge sets full");
      level = 1000; tick(1, 0); chk(am ? "R9 write edge keeps full" : "R8 write edge updates full");
      tick(0, 1); chk(am ? "R9 read edge clears full" : "R8 read edge no full change");
    end

    // R10: partial reset mid-sequence
    master_reset(2, 1, 1);
    par_load({$urandom, $urandom}, {$urandom, $urandom});
    idle(); ld = 1; wr_en = 1; wr_data = {$urandom, $urandom}; tick(1, 1); idle();
    level = DEPTH; tick(1, 1);
    prst_n = 0; tick(1, 1); prst_n = 1;
    chk("R10 R11 after partial reset");
    read_both("R10 offsets kept");
    par_load({$urandom, $urandom}, {$urandom, $urandom});
    read_both("R10 layout kept");

    // random phase, both styles
    for (int am = 0; am < 2; am++) begin
      master_reset($urandom_range(0, 7), am[0], $urandom_range(0, 1));
      for (int n = 0; n < 3000; n++) begin
        ld = ($urandom_range(0, 7) == 0);
        wr_en = $urandom_range(0, 1); ser_en = $urandom_range(0, 1);
        rd_en = $urandom_range(0, 1); ser_in = $urandom_range(0, 1);
        wr_data = {$urandom, $urandom};
        level = (W+1)'($urandom_range(0, DEPTH));
        if ($urandom_range(0, 3) == 0) level = (W+1)'(m_ae);
        if ($urandom_range(0, 3) == 0) level = (W+1)'(DEPTH - int'(m_af));
        tick($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0);
        chk(am ? "R9 R6 R7 random" : "R8 R6 R7 random");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule